// File: doc/BRIEF.md
# Interrupt Acknowledge Broadcaster with Storm Throttle

This block takes an end-of-interrupt notice carrying a vector and, in the cycle after it is accepted, pulses a per-pin clear for the "remote request" bit of every level-sensitive routing entry that holds that vector and still has the bit set. Entries that are edge-sensitive, hold another vector or have no outstanding remote request are not touched.

When an entry it acts on is unmasked and its pin is still asserted, the interrupt has to be delivered again. The block pulses a re-service request for the message path. Each pin also has a counter of back-to-back re-deliveries. When that counter reaches a threshold, the re-delivery is held back by a fixed countdown so that a stuck level source cannot flood the processor.

The notice can arrive as a broadcast from the interrupt fabric or as a write to an acknowledge register. The register form is honoured only when the device version is 0x20 and the write is a full 32-bit word. Message generation and register decode sit outside the block. Software writes to a routing entry reach it only as a per-pin strobe.

Top module: `eoi_storm_gate`

## Requirements
- R1: One cycle after an accepted notice, `rirr_clr[i]` is high exactly for the pins whose 8-bit entry vector equals `eoi_vector`, whose `ent_level` is 1 and whose `ent_rirr` is 1. All other bits are 0, and every bit is 0 in cycles that follow no accepted notice.
- R2: A notice with `eoi_from_reg`=0 is always accepted. A notice with `eoi_from_reg`=1 is accepted only when `dev_version` equals 8'h20 and `eoi_word_write` is 1. Otherwise it is ignored.
- R3: When an affected pin is unmasked (`ent_mask`=0) and pending (`pin_pending`=1), and its counter plus one is below `STORM_LIMIT`, `reservice_req` pulses in the cycle after the notice and the counter increments.
- R4: When that increment would reach `STORM_LIMIT`, the counter returns to zero and no immediate pulse is produced for that pin. Instead `reservice_req` pulses `DELAY_CYC` cycles after the immediate pulse would have come.
- R5: An affected pin that is masked or not pending has its counter reset to zero and causes no re-service.
- R6: A pulse on `ent_write[i]` resets pin i's counter to zero. If a notice arrives in the same cycle, its clear and re-service outcome are still computed from the old count.
- R7: A deferral that arrives while the countdown has more than one cycle left is dropped, and the running deadline is kept. A deferral that arrives when the countdown is idle or in its final cycle reloads the countdown.
- R8: While reset is asserted, `rirr_clr` and `reservice_req` are 0, all counters are zero and the countdown is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_from_reg | input | 1 | Notice came from the acknowledge register rather than the broadcast |
| eoi_word_write | input | 1 | Register write was a full 32-bit word |
| dev_version | input | 8 | Device version value |
| ent_vector | input | NPINS*VEC_W | Vector field of each routing entry, pin i at bits [i*VEC_W +: VEC_W] |
| ent_level | input | NPINS | Entry is level-sensitive |
| ent_mask | input | NPINS | Entry is masked |
| ent_rirr | input | NPINS | Entry remote-request bit |
| pin_pending | input | NPINS | Pin input still asserted |
| ent_write | input | NPINS | Software wrote pin's entry |
| rirr_clr | output | NPINS | Clear pulse for each entry's remote-request bit |
| reservice_req | output | 1 | Request to re-run delivery |

## Verification
Directed sequences first separate the match terms one at a time: a foreign vector, an edge-sensitive entry and a cleared remote-request bit must each suppress the clear, and the register path is tried with each version and word-size combination. A sustained storm on one pin shows the count at which delivery switches from immediate to delayed and where the counting restarts. Masking, a dropped pin and entry writes in the middle of a storm show the counter resets. Back-to-back storms tell a kept deadline apart from a restarted one. Several thousand random cycles over a small vector set then mix multi-pin matches with all of these.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
  // Version value that enables the register form of the acknowledge.
  localparam logic [7:0] EOI_REG_VERSION = 8'h20;
endpackage

// File: rtl/eoi_match.sv
module eoi_match #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8
) (
  input  logic               accept,
  input  logic [VEC_W-1:0]   eoi_vector,
  input  logic [NPINS*VEC_W-1:0] ent_vector,
  input  logic [NPINS-1:0]   ent_level,
  input  logic [NPINS-1:0]   ent_rirr,
  output logic [NPINS-1:0]   hit
);
  for (genvar i = 0; i < NPINS; i++) begin : g_cmp
    assign hit[i] = accept && ent_level[i] && ent_rirr[i] &&
                    (ent_vector[i*VEC_W +: VEC_W] == eoi_vector);
  end
endmodule

// File: rtl/storm_counter.sv
module storm_counter #(
  parameter int CNT_W = 14,
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ready,
  input  logic wr_clr,
  output logic now_o,
  output logic defer_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             at_limit;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    at_limit = cnt_inc >= (CNT_W+1)'(LIMIT);
    now_o    = hit && ready && !at_limit;
    defer_o  = hit && ready && at_limit;
    cnt_d    = cnt_q;
    if (wr_clr) begin
      cnt_d = '0;
    end else if (hit) begin
      if (ready && !at_limit) cnt_d = cnt_inc[CNT_W-1:0];
      else                    cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < (CNT_W+1)'(LIMIT));
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> cnt_q == '0);
  p_idle_pin_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ready) |=> cnt_q == '0);
endmodule

// File: rtl/defer_timer.sv
module defer_timer #(
  parameter int DELAY_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic defer_req,
  output logic fire
);
  localparam int TW = $clog2(DELAY_CYC + 1);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          ending;

  always_comb begin
    ending = tmr_q == TW'(1);
    fire   = ending;
    tmr_d  = tmr_q;
    if (tmr_q != '0) tmr_d = tmr_q - TW'(1);
    if (defer_req && (tmr_q == '0 || ending)) tmr_d = TW'(DELAY_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= TW'(DELAY_CYC));
  p_keep_deadline_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q > TW'(1)) |=> tmr_q == $past(tmr_q) - TW'(1));
endmodule

// File: rtl/eoi_storm_gate.sv
module eoi_storm_gate #(
  parameter int NPINS       = 24,
  parameter int VEC_W       = 8,
  parameter int CNT_W       = 14,
  parameter int STORM_LIMIT = 10000,
  parameter int DELAY_CYC   = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic                   eoi_from_reg,
  input  logic                   eoi_word_write,
  input  logic [7:0]             dev_version,
  input  logic [NPINS*VEC_W-1:0] ent_vector,
  input  logic [NPINS-1:0]       ent_level,
  input  logic [NPINS-1:0]       ent_mask,
  input  logic [NPINS-1:0]       ent_rirr,
  input  logic [NPINS-1:0]       pin_pending,
  input  logic [NPINS-1:0]       ent_write,
  output logic [NPINS-1:0]       rirr_clr,
  output logic                   reservice_req
);
  import eoi_pkg::*;

  logic             accept;
  logic [NPINS-1:0] hit, now_v, defer_v;
  logic             fire;
  logic [NPINS-1:0] clr_q;
  logic             res_q;

  assign accept = eoi_valid &&
                  (!eoi_from_reg || (eoi_word_write && dev_version == EOI_REG_VERSION));

  eoi_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_match (
    .accept(accept), .eoi_vector(eoi_vector), .ent_vector(ent_vector),
    .ent_level(ent_level), .ent_rirr(ent_rirr), .hit(hit));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    storm_counter #(.CNT_W(CNT_W), .LIMIT(STORM_LIMIT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(hit[i]),
      .ready(!ent_mask[i] && pin_pending[i]), .wr_clr(ent_write[i]),
      .now_o(now_v[i]), .defer_o(defer_v[i]));

    p_clr_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rirr_clr[i] |-> $past(eoi_valid && ent_level[i] && ent_rirr[i] &&
                            ent_vector[i*VEC_W +: VEC_W] == eoi_vector));
  end

  defer_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .defer_req(|defer_v), .fire(fire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= '0;
      res_q <= 1'b0;
    end else begin
      clr_q <= hit;
      res_q <= (|now_v) || fire;
    end
  end

  assign rirr_clr      = clr_q;
  assign reservice_req = res_q;

  p_reg_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_from_reg && dev_version != EOI_REG_VERSION) |=> rirr_clr == '0);
  p_no_clr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |=> rirr_clr == '0);
endmodule

// File: tb/eoi_storm_gate_test.sv
module eoi_storm_gate_test;
  localparam int NP  = 8;
  localparam int VW  = 8;
  localparam int LIM = 4;
  localparam int DLY = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic eoi_valid, eoi_from_reg, eoi_word_write;
  logic [VW-1:0] eoi_vector;
  logic [7:0] dev_version;
  logic [NP*VW-1:0] ent_vector;
  logic [NP-1:0] ent_level, ent_mask, ent_rirr, pin_pending, ent_write;
  logic [NP-1:0] rirr_clr;
  logic reservice_req;

  int errors = 0, checks = 0;
  bit done = 0;
  int mcnt [NP];
  int mtmr;
  logic [NP-1:0] exp_clr;
  logic exp_res;

  always #10 clk = ~clk;

  eoi_storm_gate #(.NPINS(NP), .VEC_W(VW), .CNT_W(14), .STORM_LIMIT(LIM),
                   .DELAY_CYC(DLY)) uut (.*);

  // Reference model: one call per clock edge, from the inputs now driven.
  task automatic model_step();
    bit acc, imm, dfr;
    acc = eoi_valid && (!eoi_from_reg || (eoi_word_write && dev_version == 8'h20));
    imm = 0; dfr = 0;
    for (int i = 0; i < NP; i++) begin
      bit h;
      int nc;
      h = acc && ent_level[i] && ent_rirr[i] && ent_vector[i*VW +: VW] == eoi_vector;
      exp_clr[i] = h;
      nc = mcnt[i];
      if (h) begin
        if (!ent_mask[i] && pin_pending[i]) begin
          if (mcnt[i] + 1 >= LIM) begin nc = 0; dfr = 1; end
          else begin nc = mcnt[i] + 1; imm = 1; end
        end else nc = 0;
      end
      if (ent_write[i]) nc = 0;
      mcnt[i] = nc;
    end
    exp_res = imm || (mtmr == 1);
    if (dfr && mtmr <= 1) mtmr = DLY;
    else if (mtmr != 0) mtmr = mtmr - 1;
  endtask

  task automatic cycle(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rirr_clr !== exp_clr || reservice_req !== exp_res) begin
      errors++;
      $display("FAIL %s: clr=%b res=%b expected clr=%b res=%b",
               tag, rirr_clr, reservice_req, exp_clr, exp_res);
    end
    eoi_valid = 0; ent_write = '0;
  endtask

  task automatic set_pin(int i, logic [7:0] v, logic lv, logic mk, logic rr, logic pd);
    ent_vector[i*VW +: VW] = v; ent_level[i] = lv; ent_mask[i] = mk;
    ent_rirr[i] = rr; pin_pending[i] = pd;
  endtask

  task automatic eoi(logic [7:0] v, logic fr, logic ww, logic [7:0] ver);
    eoi_valid = 1; eoi_vector = v; eoi_from_reg = fr; eoi_word_write = ww; dev_version = ver;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) cycle(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rst_n = 0; eoi_valid = 0; eoi_vector = 0; eoi_from_reg = 0; eoi_word_write = 0;
    dev_version = 8'h20; ent_write = '0;
    for (int i = 0; i < NP; i++) begin set_pin(i, 8'h10, 1, 0, 0, 0); mcnt[i] = 0; end
    mtmr = 0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (rirr_clr !== '0 || reservice_req !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: clr=%b res=%b expected clr=0 res=0", rirr_clr, reservice_req);
    end
    rst_n = 1;
    idle(2, "R8 after reset");

    // R1: match terms, one at a time
    set_pin(3, 8'h41, 1, 0, 1, 1);
    set_pin(5, 8'h41, 0, 0, 1, 1);   // edge entry
    set_pin(6, 8'h41, 1, 0, 0, 1);   // no remote request
    set_pin(2, 8'h42, 1, 0, 1, 1);   // other vector
    eoi(8'h41, 0, 0, 8'h11); cycle("R1 R3 single match");
    idle(2, "R1 quiet");
    // R2: register path gating
    eoi(8'h41, 1, 1, 8'h11); cycle("R2 reg old version");
    eoi(8'h41, 1, 0, 8'h20); cycle("R2 reg partial write");
    eoi(8'h41, 1, 1, 8'h20); cycle("R2 reg accepted");
    idle(DLY + 2, "R4 drain");
    // R3 R4: storm on pin 3 with gaps
    for (int k = 0; k < 2 * LIM + 1; k++) begin
      eoi(8'h41, 0, 0, 8'h20); cycle("R3 R4 storm");
      idle(DLY + 1, "R4 deferred pulse");
    end
    // R5: masked then not pending reset the count
    eoi(8'h41, 0, 0, 8'h20); cycle("R3 pre mask");
    ent_mask[3] = 1; eoi(8'h41, 0, 0, 8'h20); cycle("R5 masked");
    ent_mask[3] = 0;
    for (int k = 0; k < LIM; k++) begin eoi(8'h41, 0, 0, 8'h20); cycle("R5 recount"); end
    idle(DLY + 1, "R5 drain");
    pin_pending[3] = 0; eoi(8'h41, 0, 0, 8'h20); cycle("R5 not pending");
    pin_pending[3] = 1;
    // R6: entry write mid-storm, also together with a notice
    eoi(8'h41, 0, 0, 8'h20); cycle("R6 pre write");
    eoi(8'h41, 0, 0, 8'h20); cycle("R6 pre write");
    ent_write[3] = 1; cycle("R6 write");
    eoi(8'h41, 0, 0, 8'h20); ent_write[3] = 1; cycle("R6 write with notice");
    for (int k = 0; k < LIM; k++) begin eoi(8'h41, 0, 0, 8'h20); cycle("R6 recount"); end
    idle(DLY + 1, "R6 drain");
    // R7: back-to-back storm, deferrals overlap the countdown
    for (int k = 0; k < 6 * LIM; k++) begin eoi(8'h41, 0, 0, 8'h20); cycle("R7 overlap"); end
    idle(DLY + 2, "R7 drain");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NP; i++)
        set_pin(i, 8'h50 + 8'($urandom_range(0, 2)), ($urandom_range(0, 7) != 0),
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) != 0),
                ($urandom_range(0, 5) != 0));
      if ($urandom_range(0, 2) != 0)
        eoi(8'h50 + 8'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) != 0), ($urandom_range(0, 1) != 0) ? 8'h20 : 8'h11);
      if ($urandom_range(0, 15) == 0) ent_write[$urandom_range(0, NP - 1)] = 1;
      cycle("R1 R2 R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule